// File: doc/BRIEF.md
# Competitive Snooping Update Counter

This block is the coherence-policy core of a small direct-mapped cache that keeps shared lines up to date through write-update traffic. Each line has a cost counter. The counter starts at the number of bus cycles that one block transfer costs. Every update that another processor pushes onto a shared copy uses up one unit of that budget. When the budget is gone, the copy drops itself. At that point the bus has spent as much on updates as a fresh re-read would cost, so a cache holding data that is no longer in active use stops paying for it.

The block watches two things: snooped bus commands (a write broadcast or a read, with the block address and the number of the issuing processor) and accesses from the local processor. In the same cycle as a snooped command, it drives a shared response. A writer that sees no cache asserting this response stops broadcasting for that address. One cycle after a line drops its copy, the block pulses an invalidate event that carries the line index. A stale line keeps its tag. When another processor rereads that address, the stale line picks up the data from the read on the bus and returns to service with a full budget. Data storage and bus arbitration lie outside this block.

Top module: `comp_snoop_counter`

## Requirements
- R1: After reset, every line is empty, `sharedOut` is low and `invValid` is low.
- R2: A local access (`cpuValid`) to address `cpuAddr` installs that block in line `cpuAddr[IDX_W-1:0]` with tag `cpuAddr[ADDR_W-1:IDX_W]`. The line becomes valid, its counter is set to `XFER_COST`, and any recorded writer is forgotten.
- R3: A foreign write broadcast (`snpIsWrite`=1, `snpSrc`≠`MY_ID`) that hits a valid line decrements the line's counter by one. It does so when no writer is recorded or when the recorded writer is the issuer, and it then records the issuer. While the result stays nonzero, `sharedOut` is high in the same cycle.
- R4: The broadcast that brings the counter to zero invalidates the line and holds `sharedOut` low in its own cycle. After a fill, this is exactly the `XFER_COST`-th consecutive broadcast from one writer. In the next cycle `invValid` is high for one cycle, with `invIndex` equal to the line index. The counter never wraps.
- R5: A foreign write broadcast from a processor other than the recorded writer reloads the counter to `XFER_COST` without decrementing it, records the new writer and drives `sharedOut` high.
- R6: A command with `snpSrc`=`MY_ID`, a command whose tag differs from the stored tag, and a command to an empty line all leave the line state and counter unchanged and keep `sharedOut` low.
- R7: A foreign read (`snpIsWrite`=0) that hits a stale line with a matching tag makes the line valid again, sets its counter to `XFER_COST` and drives `sharedOut` high. A foreign read that hits a valid line drives `sharedOut` high and leaves the counter unchanged.
- R8: A write broadcast that hits a stale line is ignored and `sharedOut` stays low.
- R9: When a local access and a snooped command address the same line in one cycle, the local access decides the line's next state. In that case `sharedOut` is high exactly when the two tags are equal.
- R10: A local access to a valid line in the middle of a count sets its counter back to `XFER_COST`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| snpValid | input | 1 | A snooped bus command is present |
| snpIsWrite | input | 1 | 1 = write broadcast, 0 = read |
| snpAddr | input | ADDR_W | Block address of the snooped command |
| snpSrc | input | ID_W | Number of the processor issuing the command |
| cpuValid | input | 1 | Local processor access present |
| cpuAddr | input | ADDR_W | Block address of the local access |
| sharedOut | output | 1 | Shared response for the current snooped command |
| invValid | output | 1 | A line invalidated itself in the previous cycle |
| invIndex | output | IDX_W | Index of the invalidated line |

## Verification
The two functions that can fall in the same cycle are the local refresh of a line and a snooped command that addresses the same line. The bench provokes the collision at the worst moment: the counter has one unit left, and a local access to that line arrives together with the broadcast that would otherwise invalidate it. It expects `sharedOut` high and no invalidate event. It then shows that a full `XFER_COST` run of broadcasts is needed to kill the line. A second collision pairs a local access that replaces the line with a different tag against a write to the old tag. There the bench expects a low response and expects the new tag alone to answer afterwards.

// File: rtl/comp_snoop_pkg.sv
package comp_snoop_pkg;

  typedef enum logic [1:0] {
    LINE_EMPTY = 2'd0,
    LINE_VALID = 2'd1,
    LINE_STALE = 2'd2
  } lineState_e;

  // Strobes from the control to the line store; at most one snoop action per cycle
  typedef struct packed {
    logic cpuLoad;    // install / refresh line at cpu index
    logic snpDec;     // decrement counter at snoop index, record writer
    logic snpReload;  // new writer: full counter, record writer
    logic snpKill;    // counter exhausted: line goes stale
    logic snpRevive;  // read on bus refills stale copy
  } lineStrobes_t;

endpackage

// File: rtl/csu_line_store.sv
module csu_line_store
  import comp_snoop_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int TAG_W     = 9,
  parameter int ID_W      = 2,
  parameter int XFER_COST = 8,
  localparam int IDX_W    = $clog2(NUM_LINES),
  localparam int CNT_W    = $clog2(XFER_COST + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  lineStrobes_t       strb,
  input  logic [IDX_W-1:0]   cpuIdx,
  input  logic [TAG_W-1:0]   cpuTag,
  input  logic [IDX_W-1:0]   snpIdx,
  input  logic [ID_W-1:0]    snpSrc,
  output lineState_e         snpState,
  output logic [TAG_W-1:0]   snpTagQ,
  output logic [CNT_W-1:0]   snpCnt,
  output logic               snpWrKnown,
  output logic [ID_W-1:0]    snpWriter,
  output logic               invValid,
  output logic [IDX_W-1:0]   invIndex
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(XFER_COST);

  lineState_e       stateQ  [NUM_LINES];
  logic [TAG_W-1:0] tagQ    [NUM_LINES];
  logic [CNT_W-1:0] cntQ    [NUM_LINES];
  logic             wrKnownQ[NUM_LINES];
  logic [ID_W-1:0]  writerQ [NUM_LINES];

  assign snpState   = stateQ[snpIdx];
  assign snpTagQ    = tagQ[snpIdx];
  assign snpCnt     = cntQ[snpIdx];
  assign snpWrKnown = wrKnownQ[snpIdx];
  assign snpWriter  = writerQ[snpIdx];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic cpuHere;
    logic snpHere;
    assign cpuHere = strb.cpuLoad && (cpuIdx == IDX_W'(i));
    assign snpHere = (snpIdx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stateQ[i]   <= LINE_EMPTY;
        tagQ[i]     <= '0;
        cntQ[i]     <= '0;
        wrKnownQ[i] <= 1'b0;
        writerQ[i]  <= '0;
      end else if (cpuHere) begin
        stateQ[i]   <= LINE_VALID;
        tagQ[i]     <= cpuTag;
        cntQ[i]     <= FULL_CNT;
        wrKnownQ[i] <= 1'b0;
      end else if (snpHere) begin
        if (strb.snpKill) begin
          stateQ[i]   <= LINE_STALE;
          cntQ[i]     <= '0;
          wrKnownQ[i] <= 1'b0;
        end else if (strb.snpDec) begin
          cntQ[i]     <= (cntQ[i] == '0) ? '0 : cntQ[i] - CNT_W'(1);
          wrKnownQ[i] <= 1'b1;
          writerQ[i]  <= snpSrc;
        end else if (strb.snpReload) begin
          cntQ[i]     <= FULL_CNT;
          wrKnownQ[i] <= 1'b1;
          writerQ[i]  <= snpSrc;
        end else if (strb.snpRevive) begin
          stateQ[i]   <= LINE_VALID;
          cntQ[i]     <= FULL_CNT;
          wrKnownQ[i] <= 1'b0;
        end
      end
    end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
      cntQ[i] <= FULL_CNT);

    // R4
    valid_cnt_live_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stateQ[i] == LINE_VALID) |-> (cntQ[i] != '0));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      invValid <= 1'b0;
      invIndex <= '0;
    end else begin
      invValid <= strb.snpKill;
      invIndex <= snpIdx;
    end
  end

  // R2
  cpu_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.cpuLoad |=> (stateQ[$past(cpuIdx)] == LINE_VALID) &&
                     (cntQ[$past(cpuIdx)] == FULL_CNT));

  // R4
  kill_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.snpKill |=> invValid && (invIndex == $past(snpIdx)) &&
                     (stateQ[$past(snpIdx)] == LINE_STALE));

  // R7
  revive_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.snpRevive && !strb.cpuLoad) |=> (stateQ[$past(snpIdx)] == LINE_VALID) &&
                                         (cntQ[$past(snpIdx)] == FULL_CNT));

endmodule

// File: rtl/csu_ctrl.sv
module csu_ctrl
  import comp_snoop_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_LINES = 8,
  parameter int ID_W      = 2,
  parameter int MY_ID     = 0,
  parameter int XFER_COST = 8,
  localparam int IDX_W    = $clog2(NUM_LINES),
  localparam int TAG_W    = ADDR_W - IDX_W,
  localparam int CNT_W    = $clog2(XFER_COST + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              snpValid,
  input  logic              snpIsWrite,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [ID_W-1:0]   snpSrc,
  input  logic              cpuValid,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  lineState_e        snpState,
  input  logic [TAG_W-1:0]  snpTagQ,
  input  logic [CNT_W-1:0]  snpCnt,
  input  logic              snpWrKnown,
  input  logic [ID_W-1:0]   snpWriter,
  output lineStrobes_t      strb,
  output logic [IDX_W-1:0]  snpIdx,
  output logic [IDX_W-1:0]  cpuIdx,
  output logic [TAG_W-1:0]  cpuTag,
  output logic              sharedOut
);

  logic [TAG_W-1:0] snpTag;
  logic foreign, tagHit, sameLine, liveHit, staleHit, lastUnit, otherWriter;

  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[ADDR_W-1:IDX_W];
  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];

  assign foreign     = snpValid && (snpSrc != ID_W'(MY_ID));
  assign tagHit      = foreign && (snpTagQ == snpTag);
  assign sameLine    = cpuValid && (cpuIdx == snpIdx);
  assign liveHit     = tagHit && (snpState == LINE_VALID);
  assign staleHit    = tagHit && (snpState == LINE_STALE);
  assign lastUnit    = (snpCnt <= CNT_W'(1));
  assign otherWriter = snpWrKnown && (snpWriter != snpSrc);

  always_comb begin
    strb           = '0;
    strb.cpuLoad   = cpuValid;
    if (!sameLine) begin
      if (snpIsWrite && liveHit) begin
        if (otherWriter)   strb.snpReload = 1'b1;
        else if (lastUnit) strb.snpKill   = 1'b1;
        else               strb.snpDec    = 1'b1;
      end else if (!snpIsWrite && staleHit) begin
        strb.snpRevive = 1'b1;
      end
    end
  end

  always_comb begin
    if (!foreign)      sharedOut = 1'b0;
    else if (sameLine) sharedOut = (cpuTag == snpTag);
    else if (snpIsWrite) sharedOut = liveHit && !strb.snpKill;
    else               sharedOut = liveHit || staleHit;
  end

  // R3
  one_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.snpDec, strb.snpReload, strb.snpKill, strb.snpRevive}));

  // R8
  stale_write_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpIsWrite && (snpState == LINE_STALE) && !sameLine) |-> !sharedOut);

  // R9
  cpu_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    sameLine |-> !(strb.snpDec || strb.snpReload || strb.snpKill || strb.snpRevive));

endmodule

// File: rtl/comp_snoop_counter.sv
module comp_snoop_counter
  import comp_snoop_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_LINES = 8,
  parameter int ID_W      = 2,
  parameter int MY_ID     = 0,
  parameter int XFER_COST = 8,
  localparam int IDX_W    = $clog2(NUM_LINES),
  localparam int TAG_W    = ADDR_W - IDX_W,
  localparam int CNT_W    = $clog2(XFER_COST + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              snpValid,
  input  logic              snpIsWrite,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [ID_W-1:0]   snpSrc,
  input  logic              cpuValid,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              sharedOut,
  output logic              invValid,
  output logic [IDX_W-1:0]  invIndex
);

  lineStrobes_t     strb;
  lineState_e       snpState;
  logic [TAG_W-1:0] snpTagQ, cpuTag;
  logic [CNT_W-1:0] snpCnt;
  logic             snpWrKnown;
  logic [ID_W-1:0]  snpWriter;
  logic [IDX_W-1:0] snpIdx, cpuIdx;

  csu_ctrl #(
    .ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES), .ID_W(ID_W),
    .MY_ID(MY_ID), .XFER_COST(XFER_COST)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .snpValid(snpValid), .snpIsWrite(snpIsWrite), .snpAddr(snpAddr), .snpSrc(snpSrc),
    .cpuValid(cpuValid), .cpuAddr(cpuAddr),
    .snpState(snpState), .snpTagQ(snpTagQ), .snpCnt(snpCnt),
    .snpWrKnown(snpWrKnown), .snpWriter(snpWriter),
    .strb(strb), .snpIdx(snpIdx), .cpuIdx(cpuIdx), .cpuTag(cpuTag),
    .sharedOut(sharedOut)
  );

  csu_line_store #(
    .NUM_LINES(NUM_LINES), .TAG_W(TAG_W), .ID_W(ID_W), .XFER_COST(XFER_COST)
  ) store_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cpuIdx(cpuIdx), .cpuTag(cpuTag), .snpIdx(snpIdx), .snpSrc(snpSrc),
    .snpState(snpState), .snpTagQ(snpTagQ), .snpCnt(snpCnt),
    .snpWrKnown(snpWrKnown), .snpWriter(snpWriter),
    .invValid(invValid), .invIndex(invIndex)
  );

  // R6
  own_src_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && (snpSrc == ID_W'(MY_ID))) |-> !sharedOut);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !snpValid |-> !sharedOut);

endmodule

// File: tb/comp_snoop_counter_tb_top.sv
`timescale 1ns/1ps
module comp_snoop_counter_tb_top;

  localparam int COST = 8;
  localparam logic [11:0] ADDR_A = 12'h025; // line 5, tag 4
  localparam logic [11:0] ADDR_B = 12'h045; // line 5, tag 8
  localparam logic [11:0] ADDR_E = 12'h002; // line 2, never filled

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic snpValid = 1'b0, snpIsWrite = 1'b0, cpuValid = 1'b0;
  logic [11:0] snpAddr = '0, cpuAddr = '0;
  logic [1:0] snpSrc = '0;
  logic sharedOut, invValid;
  logic [2:0] invIndex;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  comp_snoop_counter #(.XFER_COST(COST)) dut_i (
    .clk(clk), .rstN(rstN),
    .snpValid(snpValid), .snpIsWrite(snpIsWrite), .snpAddr(snpAddr), .snpSrc(snpSrc),
    .cpuValid(cpuValid), .cpuAddr(cpuAddr),
    .sharedOut(sharedOut), .invValid(invValid), .invIndex(invIndex)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One snooped command; response checked in its cycle, event checked in the next
  task automatic snoop(input bit isW, input logic [11:0] a, input logic [1:0] src,
                       input bit expSh, input bit expInv, input string req);
    @(negedge clk);
    snpValid = 1'b1; snpIsWrite = isW; snpAddr = a; snpSrc = src;
    #2 chk(sharedOut == expSh, {req, " shared"}, sharedOut, expSh);
    @(negedge clk);
    snpValid = 1'b0;
    chk(invValid == expInv, {req, " inv"}, invValid, expInv);
    if (expInv) chk(invIndex == a[2:0], {req, " invIndex"}, invIndex, a[2:0]);
  endtask

  task automatic liveWrites(input int n, input logic [11:0] a, input logic [1:0] src,
                            input string req);
    for (int k = 0; k < n; k++) snoop(1'b1, a, src, 1'b1, 1'b0, req);
  endtask

  task automatic cpuAccess(input logic [11:0] a);
    @(negedge clk);
    cpuValid = 1'b1; cpuAddr = a;
    @(negedge clk);
    cpuValid = 1'b0;
  endtask

  task automatic collide(input logic [11:0] ca, input logic [11:0] sa, input logic [1:0] src,
                         input bit expSh, input string req);
    @(negedge clk);
    cpuValid = 1'b1; cpuAddr = ca;
    snpValid = 1'b1; snpIsWrite = 1'b1; snpAddr = sa; snpSrc = src;
    #2 chk(sharedOut == expSh, {req, " shared"}, sharedOut, expSh);
    @(negedge clk);
    cpuValid = 1'b0; snpValid = 1'b0;
    chk(invValid == 1'b0, {req, " inv"}, invValid, 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(sharedOut == 1'b0, "R1 shared", sharedOut, 0);
    chk(invValid == 1'b0, "R1 inv", invValid, 0);
    snoop(1'b0, ADDR_A, 2'd1, 1'b0, 1'b0, "R1 empty line read");
  endtask

  task automatic testFillAndCount();
    cpuAccess(ADDR_A);
    liveWrites(COST - 1, ADDR_A, 2'd1, "R3 decrement");
    snoop(1'b1, ADDR_A, 2'd1, 1'b0, 1'b1, "R4 last broadcast");
    snoop(1'b1, ADDR_A, 2'd1, 1'b0, 1'b0, "R8 stale write");
  endtask

  task automatic testReread();
    snoop(1'b0, ADDR_A, 2'd2, 1'b1, 1'b0, "R7 revive");
    liveWrites(COST - 1, ADDR_A, 2'd1, "R7 full after revive");
    snoop(1'b1, ADDR_A, 2'd1, 1'b0, 1'b1, "R7 kill after revive");
  endtask

  task automatic testWriterSwitch();
    snoop(1'b0, ADDR_A, 2'd2, 1'b1, 1'b0, "R5 revive");
    liveWrites(5, ADDR_A, 2'd1, "R5 first writer");
    snoop(1'b1, ADDR_A, 2'd2, 1'b1, 1'b0, "R5 switch");
    liveWrites(COST - 1, ADDR_A, 2'd2, "R5 after switch");
    snoop(1'b1, ADDR_A, 2'd2, 1'b0, 1'b1, "R5 kill");
  endtask

  task automatic testLocalReload();
    snoop(1'b0, ADDR_A, 2'd3, 1'b1, 1'b0, "R10 revive");
    liveWrites(6, ADDR_A, 2'd1, "R10 partial");
    cpuAccess(ADDR_A);
    liveWrites(COST - 1, ADDR_A, 2'd1, "R10 after reload");
    snoop(1'b1, ADDR_A, 2'd1, 1'b0, 1'b1, "R10 kill");
  endtask

  task automatic testIgnored();
    snoop(1'b0, ADDR_A, 2'd2, 1'b1, 1'b0, "R6 revive");
    snoop(1'b1, ADDR_A, 2'd0, 1'b0, 1'b0, "R6 own write");
    snoop(1'b0, ADDR_A, 2'd0, 1'b0, 1'b0, "R6 own read");
    snoop(1'b1, ADDR_B, 2'd1, 1'b0, 1'b0, "R6 tag miss");
    snoop(1'b1, ADDR_E, 2'd1, 1'b0, 1'b0, "R6 empty line");
    snoop(1'b0, ADDR_A, 2'd2, 1'b1, 1'b0, "R7 read of valid line");
    liveWrites(COST - 1, ADDR_A, 2'd1, "R6 counter untouched");
    snoop(1'b1, ADDR_A, 2'd1, 1'b0, 1'b1, "R6 kill");
  endtask

  task automatic testCollision();
    snoop(1'b0, ADDR_A, 2'd2, 1'b1, 1'b0, "R9 revive");
    liveWrites(COST - 1, ADDR_A, 2'd1, "R9 to last unit");
    collide(ADDR_A, ADDR_A, 2'd1, 1'b1, "R9 same tag");
    liveWrites(COST - 1, ADDR_A, 2'd1, "R9 full after collide");
    snoop(1'b1, ADDR_A, 2'd1, 1'b0, 1'b1, "R9 kill");
    snoop(1'b0, ADDR_A, 2'd2, 1'b1, 1'b0, "R9 revive again");
    collide(ADDR_B, ADDR_A, 2'd1, 1'b0, "R9 replacement");
    snoop(1'b1, ADDR_A, 2'd1, 1'b0, 1'b0, "R9 old tag gone");
    snoop(1'b1, ADDR_B, 2'd1, 1'b1, 1'b0, "R9 new tag live");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testFillAndCount();
    testReread();
    testWriterSwitch();
    testLocalReload();
    testIgnored();
    testCollision();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule